// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Controller

This block collects interrupt sources from the channels of a multi-channel serial card and merges them into one interrupt request line. Each source has a trigger type that is fixed when the block is built. Edge sources latch a status bit when their input makes the selected transition, either low-to-high or high-to-low. Level sources latch whenever their input is high. Each source passes through a two-flop synchronizer before any detection takes place.

Software reaches four 32-bit registers over a simple local bus. Writes take one cycle and reads are combinational from the address. The enable register gates each source. The status register shows what has latched, and writing 1 to a status bit clears it. The type register reports which sources are level triggered and cannot be written. The polarity register picks the active edge of each edge source.

Disabling a source drops its latch. Level sources also show their live input in the status view, even while disabled. A level source that is enabled and still high latches again in the same cycle that software clears it.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable, status and polarity registers read 0 and irqOut is 0.
- R2: The enable register at offset 0x60 reads back what was written; bit i set to 1 lets source i latch, and a 0 blocks it.
- R3: An enabled edge source latches its status bit (offset 0x64) on a rising input when its polarity bit is 0 and on a falling input when it is 1. The input passes a two-flop synchronizer, and one transition latches the bit once.
- R4: Writing to offset 0x64 clears exactly the status bits written as 1. Bits written as 0, and bits that were not set, are unaffected.
- R5: Clearing an enable bit drops that source's latched status in the next cycle. Transitions that arrive while a source is disabled are never recorded.
- R6: A level source's status bit reads 1 whenever its synchronized input is high, even while the source is disabled. A disabled source never drives irqOut.
- R7: An enabled level source whose input is still high stays latched through a clear, so irqOut stays high with no gap.
- R8: Offset 0x68 reads the fixed type mask LEVEL_MASK (1 = level, default 0xC0, so sources 6 and 7 are level). Writes to it are ignored.
- R9: The polarity register at offset 0x6C stores bits only for edge sources. Bits for level sources always read 0, which means active high.
- R10: irqOut is a register. It goes high one cycle after any enabled status bit latches, and it goes low one cycle after all enabled status bits are cleared.
- R11: If a new edge event and a clear of the same bit land in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC | Raw interrupt source inputs |
| wrEn | input | 1 | Bus write strobe, one cycle per write |
| addr | input | ADDR_W | Bus register offset for reads and writes |
| wrData | input | DATA_W | Bus write data |
| rdData | output | DATA_W | Bus read data for the current addr |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The assertions assume that each bus write is a single-cycle wrEn pulse with addr and wrData steady around the sampling edge. They also assume that srcIn changes only between clock edges, so each transition is seen once, in order, through the synchronizer. The bench drives every input on the falling edge and holds each source level for at least four cycles before it reads status or irqOut. The one exception is the same-cycle case for R11: there the bench counts edges exactly, so that the clear write lands on the edge where the synchronized transition is latched.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef struct packed {
    logic wrEnable;
    logic wrClear;
    logic wrPolarity;
  } irqStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ENABLE,
    RD_STATUS,
    RD_TYPE,
    RD_POLARITY
  } rdSel_e;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chainQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chainQ <= '0;
    else       chainQ <= {chainQ[STAGES-2:0], din};
  end

  assign dout = chainQ[STAGES-1];

endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int                ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] OFF_ENABLE   = 8'h60,
  parameter logic [ADDR_W-1:0] OFF_STATUS   = 8'h64,
  parameter logic [ADDR_W-1:0] OFF_TYPE     = 8'h68,
  parameter logic [ADDR_W-1:0] OFF_POLARITY = 8'h6C
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output irqStrobe_t        strobe,
  output rdSel_e            rdSel
);

  always_comb begin
    strobe = '0;
    rdSel  = RD_NONE;
    case (addr)
      OFF_ENABLE: begin
        rdSel           = RD_ENABLE;
        strobe.wrEnable = wrEn;
      end
      OFF_STATUS: begin
        rdSel          = RD_STATUS;
        strobe.wrClear = wrEn;
      end
      OFF_TYPE: begin
        rdSel = RD_TYPE;
      end
      OFF_POLARITY: begin
        rdSel             = RD_POLARITY;
        strobe.wrPolarity = wrEn;
      end
      default: rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int                 NUM_SRC    = 8,
  parameter int                 DATA_W     = 32,
  parameter int                 SYNC_DEPTH = 2,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hC0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  irqStrobe_t         strobe,
  input  rdSel_e             rdSel,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut,
  output logic [NUM_SRC-1:0] srcCur,
  output logic [NUM_SRC-1:0] srcLast,
  output logic [NUM_SRC-1:0] enableQ,
  output logic [NUM_SRC-1:0] polarityQ,
  output logic [NUM_SRC-1:0] latchQ
);

  localparam logic [NUM_SRC-1:0] EDGE_MASK = ~LEVEL_MASK;

  logic [NUM_SRC-1:0] wrBits;
  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] viewBits;
  logic [NUM_SRC-1:0] clrMask;
  logic [NUM_SRC-1:0] latchNext;

  assign wrBits = wrData[NUM_SRC-1:0];

  if (DATA_W > NUM_SRC) begin : g_pad
    logic unusedHi;
    assign unusedHi = ^wrData[DATA_W-1:NUM_SRC];
  end

  irqc_sync #(
    .WIDTH  (NUM_SRC),
    .STAGES (SYNC_DEPTH)
  ) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (srcIn),
    .dout (srcCur)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcLast <= '0;
    else       srcLast <= srcCur;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      assign hit[i]      = srcCur[i];
      assign viewBits[i] = latchQ[i] | srcCur[i];
    end else begin : g_edge
      assign hit[i]      = polarityQ[i] ? (srcLast[i] & ~srcCur[i])
                                        : (srcCur[i] & ~srcLast[i]);
      assign viewBits[i] = latchQ[i];
    end
  end

  assign clrMask   = strobe.wrClear ? wrBits : '0;
  assign latchNext = ((latchQ & ~clrMask) | hit) & enableQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ   <= '0;
      polarityQ <= '0;
      latchQ    <= '0;
      irqOut    <= 1'b0;
    end else begin
      if (strobe.wrEnable)   enableQ   <= wrBits;
      if (strobe.wrPolarity) polarityQ <= wrBits & EDGE_MASK;
      latchQ <= latchNext;
      irqOut <= |(latchQ & enableQ);
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      RD_ENABLE:   rdData[NUM_SRC-1:0] = enableQ;
      RD_STATUS:   rdData[NUM_SRC-1:0] = viewBits;
      RD_TYPE:     rdData[NUM_SRC-1:0] = LEVEL_MASK;
      RD_POLARITY: rdData[NUM_SRC-1:0] = polarityQ;
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int                 NUM_SRC      = 8,
  parameter int                 DATA_W       = 32,
  parameter int                 ADDR_W       = 8,
  parameter int                 SYNC_DEPTH   = 2,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK   = 8'hC0,
  parameter logic [ADDR_W-1:0]  OFF_ENABLE   = 8'h60,
  parameter logic [ADDR_W-1:0]  OFF_STATUS   = 8'h64,
  parameter logic [ADDR_W-1:0]  OFF_TYPE     = 8'h68,
  parameter logic [ADDR_W-1:0]  OFF_POLARITY = 8'h6C
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);

  irqStrobe_t         strobe;
  rdSel_e             rdSel;
  logic [NUM_SRC-1:0] srcCur;
  logic [NUM_SRC-1:0] srcLast;
  logic [NUM_SRC-1:0] enableQ;
  logic [NUM_SRC-1:0] polarityQ;
  logic [NUM_SRC-1:0] latchQ;

  irqc_ctrl #(
    .ADDR_W       (ADDR_W),
    .OFF_ENABLE   (OFF_ENABLE),
    .OFF_STATUS   (OFF_STATUS),
    .OFF_TYPE     (OFF_TYPE),
    .OFF_POLARITY (OFF_POLARITY)
  ) u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  irqc_datapath #(
    .NUM_SRC    (NUM_SRC),
    .DATA_W     (DATA_W),
    .SYNC_DEPTH (SYNC_DEPTH),
    .LEVEL_MASK (LEVEL_MASK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .strobe    (strobe),
    .rdSel     (rdSel),
    .wrData    (wrData),
    .rdData    (rdData),
    .irqOut    (irqOut),
    .srcCur    (srcCur),
    .srcLast   (srcLast),
    .enableQ   (enableQ),
    .polarityQ (polarityQ),
    .latchQ    (latchQ)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int                 NUM_SRC    = 8,
  parameter int                 ADDR_W     = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hC0,
  parameter logic [ADDR_W-1:0]  OFF_STATUS = 8'h64,
  parameter logic [ADDR_W-1:0]  OFF_TYPE   = 8'h68
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [NUM_SRC-1:0] wrBits,
  input logic [NUM_SRC-1:0] rdBits,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] srcCur,
  input logic [NUM_SRC-1:0] srcLast,
  input logic [NUM_SRC-1:0] enableQ,
  input logic [NUM_SRC-1:0] polarityQ,
  input logic [NUM_SRC-1:0] latchQ
);

  logic [NUM_SRC-1:0] clrReq;
  logic [NUM_SRC-1:0] edgeEvt;

  assign clrReq  = (wrEn && (addr == OFF_STATUS)) ? wrBits : '0;
  assign edgeEvt = ~LEVEL_MASK & ((polarityQ & srcLast & ~srcCur) |
                                  (~polarityQ & srcCur & ~srcLast));

  AST_CLEAR_ONLY_BY_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    (($past(latchQ) & ~latchQ & ~$past(clrReq | ~enableQ)) == '0)); // R4

  AST_DISABLED_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    ((latchQ & ~$past(enableQ)) == '0)); // R5

  AST_LEVEL_RELATCH: assert property (@(posedge clk) disable iff (!rstN)
    (($past(enableQ & srcCur) & LEVEL_MASK & ~latchQ) == '0)); // R7

  AST_TYPE_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (addr == OFF_TYPE) |-> (rdBits == LEVEL_MASK)); // R8

  AST_LEVEL_POL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((polarityQ & LEVEL_MASK) == '0)); // R9

  AST_IRQ_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ($past(latchQ) != '0)); // R10

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (($past(enableQ & edgeEvt) & ~latchQ) == '0)); // R11

endmodule

bind irqc_top irqc_checker #(
  .NUM_SRC    (NUM_SRC),
  .ADDR_W     (ADDR_W),
  .LEVEL_MASK (LEVEL_MASK),
  .OFF_STATUS (OFF_STATUS),
  .OFF_TYPE   (OFF_TYPE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrBits    (wrData[NUM_SRC-1:0]),
  .rdBits    (rdData[NUM_SRC-1:0]),
  .irqOut    (irqOut),
  .srcCur    (srcCur),
  .srcLast   (srcLast),
  .enableQ   (enableQ),
  .polarityQ (polarityQ),
  .latchQ    (latchQ)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;

  localparam int         NSRC  = 8;
  localparam logic [7:0] LVL   = 8'hC0;
  localparam logic [7:0] A_EN  = 8'h60;
  localparam logic [7:0] A_ST  = 8'h64;
  localparam logic [7:0] A_TY  = 8'h68;
  localparam logic [7:0] A_POL = 8'h6C;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] srcIn = '0;
  logic            wrEn = 1'b0;
  logic [7:0]      addr = '0;
  logic [31:0]     wrData = '0;
  logic [31:0]     rdData;
  logic            irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irqc_top u0 (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .irqOut (irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] off, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; addr = off; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic busRead(input logic [7:0] off, output logic [31:0] data);
    addr = off;
    #1;
    data = rdData;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    settle(5);
    rstN = 1'b1;
    settle(2);

    // R1 reset state, R8 type register
    busRead(A_EN, rv);  check("R1 enable", rv, 32'h0);
    busRead(A_ST, rv);  check("R1 status", rv, 32'h0);
    busRead(A_POL, rv); check("R1 polarity", rv, 32'h0);
    check("R1 irq", {31'h0, irqOut}, 32'h0);
    busRead(A_TY, rv);  check("R8 type", rv, 32'h0000_00C0);
    busWrite(A_TY, 32'hFF);
    busRead(A_TY, rv);  check("R8 type write ignored", rv, 32'h0000_00C0);

    // R9 level bits of polarity never stored
    busWrite(A_POL, 32'hFF);
    busRead(A_POL, rv); check("R9 polarity mask", rv, 32'h0000_003F);

    // R2 enable readback
    busWrite(A_EN, 32'hA5);
    busRead(A_EN, rv); check("R2 enable readback", rv, 32'h0000_00A5);

    // R3 sweep over every edge source and both polarities
    for (int i = 0; i < NSRC; i++) begin
      if (!LVL[i]) begin
        for (int p = 0; p < 2; p++) begin
          logic [31:0] bitv;
          bitv = 32'h1 << i;
          busWrite(A_EN, 32'h0);
          srcIn = '0;
          settle(4);
          busWrite(A_POL, (p == 1) ? bitv : 32'h0);
          busRead(A_POL, rv); check("R9 polarity readback", rv, (p == 1) ? bitv : 32'h0);
          busWrite(A_EN, bitv);
          srcIn[i] = 1'b1;
          settle(4);
          busRead(A_ST, rv); check("R3 rising input", rv, (p == 0) ? bitv : 32'h0);
          check("R10 irq after rise", {31'h0, irqOut}, (p == 0) ? 32'h1 : 32'h0);
          srcIn[i] = 1'b0;
          settle(4);
          busRead(A_ST, rv); check("R3 falling input", rv, bitv);
          check("R10 irq latched", {31'h0, irqOut}, 32'h1);
          busWrite(A_ST, bitv);
          settle(4);
          busRead(A_ST, rv); check("R4 cleared once", rv, 32'h0);
          check("R10 irq after clear", {31'h0, irqOut}, 32'h0);
        end
      end
    end

    // R2 disabled source does not latch
    busWrite(A_POL, 32'h0);
    busWrite(A_EN, 32'h0);
    srcIn = '0; settle(4);
    srcIn[2] = 1'b1; settle(4);
    busRead(A_ST, rv); check("R2 disabled no latch", rv, 32'h0);
    srcIn[2] = 1'b0; settle(4);

    // R4 selective clear and clear of unset bit
    busWrite(A_EN, 32'h03);
    srcIn[1:0] = 2'b11; settle(4);
    busRead(A_ST, rv); check("R4 both latched", rv, 32'h3);
    busWrite(A_ST, 32'h1); settle(2);
    busRead(A_ST, rv); check("R4 only bit0 cleared", rv, 32'h2);
    busWrite(A_ST, 32'h4); settle(2);
    busRead(A_ST, rv); check("R4 unset bit clear no effect", rv, 32'h2);

    // R5 disable drops latch, edges while disabled ignored
    busWrite(A_EN, 32'h0); settle(2);
    busRead(A_ST, rv); check("R5 disable drops", rv, 32'h0);
    check("R5 irq low", {31'h0, irqOut}, 32'h0);
    srcIn[1:0] = 2'b00; settle(4);
    srcIn[1:0] = 2'b11; settle(4);
    busWrite(A_EN, 32'h03); settle(4);
    busRead(A_ST, rv); check("R5 edges while disabled lost", rv, 32'h0);
    busWrite(A_EN, 32'h0);
    srcIn = '0; settle(4);

    // R6 level source visible while disabled
    srcIn[6] = 1'b1; settle(4);
    busRead(A_ST, rv); check("R6 live level view", rv, 32'h40);
    check("R6 no irq while disabled", {31'h0, irqOut}, 32'h0);
    busWrite(A_EN, 32'h40); settle(3);
    check("R10 level irq", {31'h0, irqOut}, 32'h1);

    // R7 clear while still high keeps irq without gap
    busWrite(A_ST, 32'h40);
    for (int k = 0; k < 4; k++) begin
      check("R7 irq held through clear", {31'h0, irqOut}, 32'h1);
      @(negedge clk);
    end
    busRead(A_ST, rv); check("R7 relatched", rv, 32'h40);
    srcIn[6] = 1'b0; settle(4);
    busRead(A_ST, rv); check("R7 latch holds after drop", rv, 32'h40);
    busWrite(A_ST, 32'h40); settle(3);
    busRead(A_ST, rv); check("R7 cleared when low", rv, 32'h0);
    check("R10 irq drops", {31'h0, irqOut}, 32'h0);
    busWrite(A_EN, 32'h0);

    // R11 event and clear in the same cycle
    busWrite(A_EN, 32'h1);
    srcIn[0] = 1'b1; settle(4);
    busRead(A_ST, rv); check("R11 first latch", rv, 32'h1);
    srcIn[0] = 1'b0; settle(4);
    srcIn[0] = 1'b1;
    @(negedge clk);
    busWrite(A_ST, 32'h1);
    settle(2);
    busRead(A_ST, rv); check("R11 event wins over clear", rv, 32'h1);
    check("R11 irq stays", {31'h0, irqOut}, 32'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule